// File: doc/BRIEF.md
# Product-Term Cluster Logic Allocator

This block is a programmable sum-of-products stage. Thirty-two data inputs and their inverses feed sixty-four AND terms. Each term has its own literal mask. The terms are grouped four at a time into sixteen clusters. A steering stage sends every cluster to at most one of sixteen macrocell outputs. Each macrocell ORs together every cluster steered to it, so one equation can collect up to eight clusters (32 terms) in a single pass.

A cluster can run in three-term mode. Its spare fourth term then becomes the second operand of the target macrocell's XOR gate, giving data-dependent polarity or a separate logic term. When no spare term reaches the XOR gate, a static per-macrocell polarity bit takes its place. Each macrocell output is either combinational or taken from a rising-edge flip-flop.

All configuration is written through a word-addressed write port. Each macrocell may draw only from a fixed window of nearby clusters. A steering outside that window is suppressed and raises a sticky error flag.

Top module: `pt_cluster_alloc`

## Requirements
- R1: Term t is the AND of the literals its 64-bit mask selects. Mask bit i (0..31) selects `dataIn[i]` and mask bit 32+i selects its inverse. An all-zero mask gives 1, and a mask that selects both a signal and its inverse gives 0.
- R2: Cluster c owns terms 4c..4c+3. In four-term mode its sum is the OR of all four terms. In three-term mode its sum is the OR of terms 4c..4c+2 only.
- R3: A valid, legally steered cluster adds its sum to exactly the macrocell given by its 4-bit target field. An invalid cluster adds to no output. A macrocell ORs all clusters that reach it.
- R4: The allowed clusters for each macrocell are: 0:C0–C4, 1:C0–C5, 2:C0–C6, 3:C0–C7, 4:C0–C7, 5:C1–C8, 6:C2–C9, 7:C3–C10, 8:C5–C12, 9:C6–C13, 10:C7–C14, 11:C8–C15, 12:C8–C15, 13:C9–C15, 14:C10–C15, 15:C11–C15.
- R5: A valid cluster that targets a macrocell outside its window adds nothing to any output. `configError` goes high one clock after that configuration takes effect and stays high until reset.
- R6: The XOR operand of a macrocell is the OR of the fourth terms of the valid, legal three-term clusters steered to it. If there are none, it is the macrocell's polarity bit. A macrocell with no clusters therefore outputs its polarity bit.
- R7: With the bypass bit 1 the output is combinational. With it 0 the output is the combinational value captured at the previous rising edge. The flip-flop clears on reset.
- R8: A write takes effect at the rising edge where `cfgWe` is sampled high. The address map is as follows. Address 2t holds mask bits 31:0 of term t, and address 2t+1 holds bits 63:32. Addresses 0x80+c hold the cluster word: bit0 valid, bits4:1 target, bit5 three-term mode. Addresses 0x90+m hold the macrocell word: bit0 polarity, bit1 bypass. Addresses 0xA0–0xFF are ignored.
- R9: Synchronous active-high reset clears every mask, cluster and macrocell word, the flip-flops and `configError`, so all outputs read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 8 | Configuration word address |
| cfgData | input | 32 | Configuration write data |
| dataIn | input | 32 | Logic inputs to the term array |
| mcOut | output | 16 | Macrocell outputs |
| configError | output | 1 | Sticky flag for out-of-window steering |

## Verification
The hardest case to reach is a macrocell that gathers many clusters, some in three-term mode, with sparse term masks. Only then do the OR sum and the XOR operand both vary with the inputs. The stimulus builds whole random configurations: masks with zero to three literals, and targets drawn mostly from each cluster's legal window, with an occasional target drawn anywhere. It then drives random input vectors under mixed bypass settings. Separate directed sweeps place clusters just inside and just outside both edges of every window.

// File: rtl/pt_alloc_pkg.sv
`timescale 1ns/1ps
package pt_alloc_pkg;
  localparam int NUM_IN       = 32;
  localparam int NUM_LIT      = 2 * NUM_IN;
  localparam int TERMS_PER_CL = 4;
  localparam int NUM_CL       = 16;
  localparam int NUM_TERMS    = NUM_CL * TERMS_PER_CL;
  localparam int NUM_MC       = 16;
  localparam int MC_W         = $clog2(NUM_MC);
  localparam int TERM_W       = $clog2(NUM_TERMS);
  localparam int CFG_AW       = 8;
  localparam int CFG_DW       = 32;
  localparam int MASK_WORDS   = NUM_TERMS * (NUM_LIT / CFG_DW);
  localparam int CL_BASE      = MASK_WORDS;
  localparam int MC_BASE      = CL_BASE + NUM_CL;
  localparam int MC_END       = MC_BASE + NUM_MC;
  localparam int WIN_SPAN     = 8;
  localparam int HALF_SPAN    = WIN_SPAN / 2;

  typedef struct packed {
    logic                  maskWe;
    logic                  clusterWe;
    logic                  mcWe;
    logic [TERM_W-1:0]     termIdx;
    logic                  upperHalf;
    logic [MC_W-1:0]       slot;
    logic [CFG_DW-1:0]     data;
    logic [NUM_CL-1:0]     legal;
  } cfgStrobe_t;

  typedef struct packed {
    logic            valid;
    logic [MC_W-1:0] target;
    logic            threeMode;
  } clusterCfg_t;

  typedef struct packed {
    logic polarity;
    logic bypass;
  } mcCfg_t;

  // window edges for the lower half; the upper half mirrors it
  function automatic int lowerLo(input int k);
    return (k <= HALF_SPAN) ? 0 : k - HALF_SPAN;
  endfunction

  function automatic int lowerHi(input int k);
    return (k < HALF_SPAN) ? k + HALF_SPAN : k + HALF_SPAN - 1;
  endfunction

  function automatic bit inWindow(input int c, input int m);
    int lo;
    int hi;
    if (m < NUM_MC / 2) begin
      lo = lowerLo(m);
      hi = lowerHi(m);
    end else begin
      lo = NUM_CL - 1 - lowerHi(NUM_MC - 1 - m);
      hi = NUM_CL - 1 - lowerLo(NUM_MC - 1 - m);
    end
    return (c >= lo) && (c <= hi);
  endfunction
endpackage

// File: rtl/pt_alloc_ctrl.sv
`timescale 1ns/1ps
module pt_alloc_ctrl
  import pt_alloc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfgWe,
  input  logic [CFG_AW-1:0]        cfgAddr,
  input  logic [CFG_DW-1:0]        cfgData,
  input  logic [NUM_CL-1:0]        clValid,
  input  logic [NUM_CL*MC_W-1:0]   clTarget,
  output cfgStrobe_t               strobe,
  output logic                     configError
);
  logic [NUM_CL-1:0] legalVec;
  logic              badSteer;

  // write decode
  always_comb begin
    strobe.maskWe    = cfgWe && (cfgAddr < CFG_AW'(MASK_WORDS));
    strobe.clusterWe = cfgWe && (cfgAddr >= CFG_AW'(CL_BASE)) && (cfgAddr < CFG_AW'(MC_BASE));
    strobe.mcWe      = cfgWe && (cfgAddr >= CFG_AW'(MC_BASE)) && (cfgAddr < CFG_AW'(MC_END));
    strobe.termIdx   = cfgAddr[TERM_W:1];
    strobe.upperHalf = cfgAddr[0];
    strobe.slot      = cfgAddr[MC_W-1:0];
    strobe.data      = cfgData;
    strobe.legal     = legalVec;
  end

  // steering legality against each macrocell window
  always_comb begin
    legalVec = '0;
    for (int c = 0; c < NUM_CL; c++) begin
      for (int m = 0; m < NUM_MC; m++) begin
        if (clTarget[c*MC_W +: MC_W] == MC_W'(m) && inWindow(c, m))
          legalVec[c] = 1'b1;
      end
    end
  end

  assign badSteer = |(clValid & ~legalVec);

  always_ff @(posedge clk) begin
    if (rst)           configError <= 1'b0;
    else if (badSteer) configError <= 1'b1;
  end

  // R5
  sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
    configError |=> configError);

  // R5
  illegal_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (|(clValid & ~strobe.legal)) |=> configError);
endmodule

// File: rtl/pt_alloc_datapath.sv
`timescale 1ns/1ps
module pt_alloc_datapath
  import pt_alloc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  cfgStrobe_t               strobe,
  input  logic [NUM_IN-1:0]        dataIn,
  output logic [NUM_MC-1:0]        mcOut,
  output logic [NUM_CL-1:0]        clValid,
  output logic [NUM_CL*MC_W-1:0]   clTarget
);
  localparam int SUM3 = TERMS_PER_CL - 1;

  logic [NUM_LIT-1:0] termMask [NUM_TERMS];
  clusterCfg_t        clCfg    [NUM_CL];
  mcCfg_t             mcCfg    [NUM_MC];
  logic [NUM_MC-1:0]  ffQ;

  logic [NUM_LIT-1:0]   literals;
  logic [NUM_TERMS-1:0] termVal;
  logic [NUM_CL-1:0]    clSum;
  logic [NUM_CL-1:0]    threeVec;
  logic [NUM_CL-1:0]    freedTerm;
  logic [NUM_CL-1:0]    routeM [NUM_MC];
  logic [NUM_MC-1:0]    sumOr;
  logic [NUM_MC-1:0]    xorIn;
  logic [NUM_MC-1:0]    comb;

  // configuration storage
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < NUM_TERMS; t++) termMask[t] <= '0;
      for (int c = 0; c < NUM_CL; c++)    clCfg[c]    <= '0;
      for (int m = 0; m < NUM_MC; m++)    mcCfg[m]    <= '0;
    end else begin
      if (strobe.maskWe) begin
        if (strobe.upperHalf)
          termMask[strobe.termIdx][NUM_LIT-1:CFG_DW] <= strobe.data;
        else
          termMask[strobe.termIdx][CFG_DW-1:0] <= strobe.data;
      end
      if (strobe.clusterWe)
        clCfg[strobe.slot] <= '{valid:     strobe.data[0],
                                target:    strobe.data[MC_W:1],
                                threeMode: strobe.data[MC_W+1]};
      if (strobe.mcWe)
        mcCfg[strobe.slot] <= '{polarity: strobe.data[0],
                                bypass:   strobe.data[1]};
    end
  end

  assign literals = {~dataIn, dataIn};

  // product terms
  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    assign termVal[t] = &(~termMask[t] | literals);
  end

  // cluster sums and freed fourth terms
  for (genvar c = 0; c < NUM_CL; c++) begin : g_cl
    assign threeVec[c]  = clCfg[c].threeMode;
    assign clSum[c]     = clCfg[c].threeMode ? |termVal[c*TERMS_PER_CL +: SUM3]
                                             : |termVal[c*TERMS_PER_CL +: TERMS_PER_CL];
    assign freedTerm[c] = termVal[c*TERMS_PER_CL + SUM3];
    assign clValid[c]   = clCfg[c].valid;
    assign clTarget[c*MC_W +: MC_W] = clCfg[c].target;
  end

  // steering, OR, XOR and output stage per macrocell
  for (genvar m = 0; m < NUM_MC; m++) begin : g_mc
    for (genvar c = 0; c < NUM_CL; c++) begin : g_route
      assign routeM[m][c] = clCfg[c].valid & strobe.legal[c] &
                            (clCfg[c].target == MC_W'(m));
    end
    assign sumOr[m] = |(routeM[m] & clSum);
    assign xorIn[m] = (|(routeM[m] & threeVec)) ? |(routeM[m] & threeVec & freedTerm)
                                                 : mcCfg[m].polarity;
    assign comb[m]  = sumOr[m] ^ xorIn[m];
    assign mcOut[m] = mcCfg[m].bypass ? comb[m] : ffQ[m];

    // R6
    empty_mc_chk: assert property (@(posedge clk) disable iff (rst)
      (routeM[m] == '0) |-> (comb[m] == mcCfg[m].polarity));

    // R8
    cfg_write_chk: assert property (@(posedge clk) disable iff (rst)
      (strobe.mcWe && strobe.slot == MC_W'(m)) |=>
        (mcCfg[m].bypass == $past(strobe.data[1]) &&
         mcCfg[m].polarity == $past(strobe.data[0])));
  end

  always_ff @(posedge clk) begin
    if (rst) ffQ <= '0;
    else     ffQ <= comb;
  end

  // R7
  reg_path_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ffQ == $past(comb)));
endmodule

// File: rtl/pt_cluster_alloc.sv
`timescale 1ns/1ps
module pt_cluster_alloc
  import pt_alloc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [CFG_DW-1:0] cfgData,
  input  logic [NUM_IN-1:0] dataIn,
  output logic [NUM_MC-1:0] mcOut,
  output logic              configError
);
  cfgStrobe_t              strobe;
  logic [NUM_CL-1:0]       clValid;
  logic [NUM_CL*MC_W-1:0]  clTarget;

  pt_alloc_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cfgWe      (cfgWe),
    .cfgAddr    (cfgAddr),
    .cfgData    (cfgData),
    .clValid    (clValid),
    .clTarget   (clTarget),
    .strobe     (strobe),
    .configError(configError)
  );

  pt_alloc_datapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .dataIn  (dataIn),
    .mcOut   (mcOut),
    .clValid (clValid),
    .clTarget(clTarget)
  );
endmodule

// File: tb/pt_cluster_alloc_test.sv
`timescale 1ns/1ps
module pt_cluster_alloc_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgWe = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic [31:0] dataIn = '0;
  logic [15:0] mcOut;
  logic        configError;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model of the configuration
  logic [63:0] mMask [64];
  bit          mValid [16];
  int          mTgt   [16];
  bit          mThree [16];
  logic [15:0] mPol;
  logic [15:0] mByp;

  always #2.5 clk = ~clk;

  pt_cluster_alloc uut (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .dataIn(dataIn), .mcOut(mcOut),
    .configError(configError)
  );

  function automatic int bLo(input int m);
    case (m)
      0, 1, 2, 3, 4: return 0;
      5: return 1;  6: return 2;  7: return 3;  8: return 5;
      9: return 6;  10: return 7; 11, 12: return 8;
      13: return 9; 14: return 10; default: return 11;
    endcase
  endfunction

  function automatic int bHi(input int m);
    case (m)
      0: return 4;  1: return 5;  2: return 6;  3, 4: return 7;
      5: return 8;  6: return 9;  7: return 10; 8: return 12;
      9: return 13; 10: return 14; default: return 15;
    endcase
  endfunction

  function automatic bit bLegal(input int c, input int m);
    return c >= bLo(m) && c <= bHi(m);
  endfunction

  function automatic logic [15:0] expComb(input logic [31:0] din);
    logic [63:0] lits;
    logic [63:0] tv;
    logic [15:0] res;
    lits = {~din, din};
    for (int t = 0; t < 64; t++) tv[t] = ((mMask[t] & ~lits) == 64'd0);
    for (int m = 0; m < 16; m++) begin
      bit s = 1'b0;
      bit xh = 1'b0;
      bit xo = 1'b0;
      for (int c = 0; c < 16; c++) begin
        if (mValid[c] && mTgt[c] == m && bLegal(c, m)) begin
          if (mThree[c]) begin
            s  = s | tv[4*c] | tv[4*c+1] | tv[4*c+2];
            xh = 1'b1;
            xo = xo | tv[4*c+3];
          end else begin
            s = s | tv[4*c] | tv[4*c+1] | tv[4*c+2] | tv[4*c+3];
          end
        end
      end
      res[m] = s ^ (xh ? xo : mPol[m]);
    end
    return res;
  endfunction

  function automatic bit expErr();
    for (int c = 0; c < 16; c++)
      if (mValid[c] && !bLegal(c, mTgt[c])) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic setMask(input int t, input logic [63:0] mk);
    cfgWrite(8'(2*t), mk[31:0]);
    cfgWrite(8'(2*t+1), mk[63:32]);
    mMask[t] = mk;
  endtask

  task automatic setCluster(input int c, input bit v, input int tg, input bit three);
    cfgWrite(8'(8'h80 + c), {26'd0, three, 4'(tg), v});
    mValid[c] = v; mTgt[c] = tg; mThree[c] = three;
  endtask

  task automatic setMc(input int m, input bit pol, input bit byp);
    cfgWrite(8'(8'h90 + m), {30'd0, byp, pol});
    mPol[m] = pol; mByp[m] = byp;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int t = 0; t < 64; t++) mMask[t] = '0;
    for (int c = 0; c < 16; c++) begin
      mValid[c] = 1'b0; mTgt[c] = 0; mThree[c] = 1'b0;
    end
    mPol = '0; mByp = '0;
  endtask

  task automatic applyComb(input logic [31:0] d, input string req);
    @(negedge clk);
    dataIn = d;
    #1;
    chk(req, {16'd0, mcOut}, {16'd0, expComb(d)});
  endtask

  // window edge probe: one cluster against one macrocell
  task automatic probeWindow(input int c, input int m);
    doReset();
    setCluster(c, 1'b1, m, 1'b0);
    @(negedge clk);
    chk($sformatf("R4 window c%0d m%0d", c, m), {31'd0, configError},
        {31'd0, !bLegal(c, m)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] prev;
    void'($urandom(32'd4242));
    doReset();
    // R9 reset state
    chk("R9 outputs after reset", {16'd0, mcOut}, 32'd0);
    chk("R9 error after reset", {31'd0, configError}, 32'd0);

    // R1 empty mask / contradiction / literal AND
    setMc(0, 1'b0, 1'b1);
    setCluster(0, 1'b1, 0, 1'b0);
    applyComb(32'h0, "R1 all-zero masks give 1");
    chk("R1 literal out", {31'd0, mcOut[0]}, 32'd1);
    for (int t = 1; t < 4; t++) setMask(t, 64'h0000_0001_0000_0001);
    applyComb(32'h0, "R1 term0 empty mask alone");
    setMask(0, 64'h0000_0001_0000_0001);
    applyComb(32'hFFFF_FFFF, "R1 contradiction gives 0");
    chk("R1 contradiction bit", {31'd0, mcOut[0]}, 32'd0);
    setMask(0, 64'h0000_0020_0000_0008);
    applyComb(32'h0000_0008, "R1 in3 and not in5 true");
    applyComb(32'h0000_0028, "R1 in3 and not in5 false");
    applyComb(32'h0000_0000, "R1 in3 missing");

    // R2 and R6: three-term mode frees term 3 to XOR
    setMask(3, 64'd0);
    applyComb(32'h0000_0008, "R2 four-term mode");
    setCluster(0, 1'b1, 0, 1'b1);
    applyComb(32'h0000_0008, "R2 three-term mode with freed xor");
    chk("R6 freed term inverts", {31'd0, mcOut[0]}, 32'd0);
    setMc(1, 1'b1, 1'b1);
    applyComb(32'h0000_0008, "R6 empty macrocell gives polarity");
    chk("R6 polarity bit", {31'd0, mcOut[1]}, 32'd1);

    // R8 write timing and ignored addresses
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 8'h91; cfgData = 32'h2;
    #1;
    chk("R8 before applying edge", {31'd0, mcOut[1]}, 32'd1);
    @(negedge clk);
    cfgWe = 1'b0; mPol[1] = 1'b0;
    #1;
    chk("R8 after applying edge", {31'd0, mcOut[1]}, 32'd0);
    cfgWrite(8'hA7, 32'hFFFF_FFFF);
    applyComb(32'h0000_0008, "R8 unmapped write ignored");
    chk("R8 no error from unmapped", {31'd0, configError}, 32'd0);

    // R3 invalid cluster and R5 suppression/sticky
    setCluster(0, 1'b0, 0, 1'b0);
    applyComb(32'h0000_0008, "R3 invalid cluster contributes nothing");
    setCluster(5, 1'b1, 0, 1'b0);
    #1;
    chk("R5 flag not yet set", {31'd0, configError}, 32'd0);
    chk("R5 illegal cluster suppressed", {31'd0, mcOut[0]}, 32'd0);
    @(negedge clk);
    chk("R5 flag set", {31'd0, configError}, 32'd1);
    setCluster(5, 1'b1, 1, 1'b0);
    @(negedge clk);
    chk("R5 flag sticky", {31'd0, configError}, 32'd1);
    doReset();
    chk("R9 reset clears error", {31'd0, configError}, 32'd0);

    // R3 many clusters into one macrocell (8 clusters to M4)
    setMc(4, 1'b0, 1'b1);
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 4; k++) setMask(4*c+k, 64'h0000_0001_0000_0001);
      setCluster(c, 1'b1, 4, 1'b0);
    end
    setMask(28, 64'h0000_0000_8000_0000);
    applyComb(32'h8000_0000, "R3 eighth cluster reaches macrocell");
    chk("R3 wide OR bit", {31'd0, mcOut[4]}, 32'd1);
    applyComb(32'h0, "R3 wide OR all false");

    // R4 window edges for every macrocell
    for (int m = 0; m < 16; m++) begin
      probeWindow(bLo(m), m);
      probeWindow(bHi(m), m);
      if (bLo(m) > 0)  probeWindow(bLo(m) - 1, m);
      if (bHi(m) < 15) probeWindow(bHi(m) + 1, m);
    end

    // random configurations, R2 R3 R6 R7 and R5
    for (int r = 0; r < 30; r++) begin
      doReset();
      for (int t = 0; t < 64; t++) begin
        logic [63:0] mk = '0;
        int k = $urandom_range(0, 3);
        for (int j = 0; j < k; j++) mk[$urandom_range(0, 63)] = 1'b1;
        setMask(t, mk);
      end
      for (int c = 0; c < 16; c++) begin
        int tg;
        if ($urandom_range(0, 7) == 0) tg = $urandom_range(0, 15);
        else begin
          tg = $urandom_range(0, 15);
          while (!bLegal(c, tg)) tg = $urandom_range(0, 15);
        end
        setCluster(c, $urandom_range(0, 3) != 0, tg, 1'($urandom_range(0, 1)));
      end
      for (int m = 0; m < 16; m++)
        setMc(m, 1'($urandom_range(0, 1)), (r % 2 == 0) ? 1'b1 : 1'($urandom_range(0, 1)));
      @(negedge clk);
      prev = dataIn;
      for (int v = 0; v < 16; v++) begin
        logic [31:0] d = $urandom;
        logic [15:0] e;
        @(negedge clk);
        dataIn = d;
        #1;
        e = (expComb(d) & mByp) | (expComb(prev) & ~mByp);
        chk("R7 R3 random outputs", {16'd0, mcOut}, {16'd0, e});
        prev = d;
      end
      chk("R5 random error flag", {31'd0, configError}, {31'd0, expErr()});
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule